// File: doc/BRIEF.md
# Four-Level Vectored Interrupt Arbiter

This block decides which of twenty interrupt sources of a small 8-bit controller is handed to the CPU next, and at which vector address the CPU should start. Each source brings a pending flag, an enable bit and a two-bit priority level. A global enable gates all of them. Arbitration runs only on a sample strobe, which the core raises at instruction boundaries. The highest requesting level wins. Within one level a fixed source order breaks ties, and that order differs from the order of the vector addresses.

The arbiter keeps a four-bit in-service mask, one bit per level. A new request is accepted only when its level is strictly above every level that is already in service, which gives nesting. A return pulse from the core retires the highest level in service. Six sources have flags that hardware clears when their vector is taken, so the arbiter sends a one-cycle clear strobe back to the owning peripheral in the same cycle as the request. The remaining flags, including every flag that is an OR of several peripheral flags, are left for software to clear. A level-triggered external input that simply follows its pin reaches this block as an ordinary pending bit.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, irqReq is 0, hwClear is all zeros and inService is 0.
- R2: A request is accepted only in a cycle where sampleStb is 1 and at least one source has both its pendIn and srcEn bits set. On acceptance, irqReq is 1 for exactly the one cycle that follows the sampling edge. In every other cycle irqReq is 0 and irqVector is 0.
- R3: Source i has its level in srcPrio[2i+1:2i], where 3 is the highest level and 0 the lowest. Among the enabled pending sources, the one at the highest level wins.
- R4: Among enabled pending sources at the winning level, the one with the lowest index wins. The bit indices 0 to 19 are: ext0, timer0, ext1, timer1, serial0, timer2, ADC, I2C, serial1, SPI, ext2, ext3, ext4, ext5, PWM period, PWM brake, timer3, capture, NVM, watchdog.
- R5: irqVector carries the winner's address. For indices 0 to 19 in order these are 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh, 0033h, 003Bh, 007Bh, 0083h, 0043h, 004Bh, 0053h, 005Bh, 0073h, 006Bh, 008Bh, 0093h, 009Bh, 0063h.
- R6: While any level is in service, a request is accepted only if its level is strictly greater than the highest level in service. Requests at that level or lower wait.
- R7: Acceptance sets bit L of inService, where L is the level of the winner. A retiPulse clears the highest set bit of inService. A sampleStb in the same cycle as retiPulse accepts nothing.
- R8: With an accepted request for source 1, 3, 10, 11, 12 or 13, hwClear has exactly that bit set for the same cycle. For every other source, and in every other cycle, hwClear is all zeros.
- R9: With globalEn at 0, or with a pending source's srcEn bit at 0, that source is ignored: no request, no clear strobe and no change to inService.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendIn | input | 20 | Per-source pending flags |
| srcEn | input | 20 | Per-source enables |
| globalEn | input | 1 | Global interrupt enable |
| srcPrio | input | 40 | Two level bits per source |
| sampleStb | input | 1 | Instruction-boundary arbitration strobe |
| retiPulse | input | 1 | Return-from-interrupt pulse |
| irqReq | output | 1 | One-cycle request to the CPU |
| irqVector | output | 16 | Vector address, valid with irqReq |
| hwClear | output | 20 | One-cycle flag clear strobes |
| inService | output | 4 | Levels currently in service |

## Verification
Every result is due exactly one clock after the rising edge that samples the stimulus. This holds for the request, the vector, the clear strobe and the in-service mask after a strobe or a return pulse. The driver stamps each expected item with the cycle count of that edge plus one. The monitor compares outputs on the falling edge only when the stamp matches the current count, so no item is checked early or late. Idle cycles also push items that expect no request, which catches strobes that last longer than one cycle.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int SRC_COUNT = 20;
  localparam int LVL_COUNT = 4;
  localparam int LVL_W     = $clog2(LVL_COUNT);
  localparam int VEC_W     = 16;
  // sources whose flag hardware clears on vector fetch: timer0, timer1, ext2..ext5
  localparam logic [SRC_COUNT-1:0] HW_CLR_MASK = 20'h03C0A;

  typedef struct packed {
    logic take;   // latch winner's vector and clear strobe this edge
  } ctlStb_t;

  // vector slot k maps to address 8*k+3; slot order differs from tie order
  function automatic logic [VEC_W-1:0] vecOf(input logic [4:0] idx);
    logic [4:0] slot;
    case (idx)
      5'd8:    slot = 5'd15;
      5'd9:    slot = 5'd16;
      5'd10:   slot = 5'd8;
      5'd11:   slot = 5'd9;
      5'd12:   slot = 5'd10;
      5'd13:   slot = 5'd11;
      5'd14:   slot = 5'd14;
      5'd15:   slot = 5'd13;
      5'd16:   slot = 5'd17;
      5'd17:   slot = 5'd18;
      5'd18:   slot = 5'd19;
      5'd19:   slot = 5'd12;
      default: slot = idx;
    endcase
    return {8'd0, slot, 3'b011};
  endfunction
endpackage

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int NUM_LVL = LVL_COUNT,
  localparam int LW     = $clog2(NUM_LVL),
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   pendIn,
  input  logic [NUM_SRC-1:0]   srcEn,
  input  logic [2*NUM_SRC-1:0] srcPrio,
  input  ctlStb_t              stb,
  output logic                 winValid,
  output logic [LW-1:0]        winLvl,
  output logic [VEC_W-1:0]     irqVector,
  output logic [NUM_SRC-1:0]   hwClear
);
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] candLvl [NUM_LVL];
  logic [NUM_LVL-1:0] lvlHit;
  logic [NUM_SRC-1:0] winSel;
  logic [IDX_W-1:0]   winIdx;

  assign cand = pendIn & srcEn;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign candLvl[l][s] = cand[s] && (srcPrio[2*s +: 2] == LW'(l));
    end
    assign lvlHit[l] = |candLvl[l];
  end

  always_comb begin
    winLvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (lvlHit[l]) winLvl = LW'(l);
  end
  assign winValid = |lvlHit;
  assign winSel   = candLvl[winLvl];

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC-1; i >= 0; i--)
      if (winSel[i]) winIdx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqVector <= '0;
      hwClear   <= '0;
    end else if (stb.take) begin
      irqVector <= vecOf(5'(winIdx));
      hwClear   <= (NUM_SRC'(1) << winIdx) & HW_CLR_MASK;
    end else begin
      irqVector <= '0;
      hwClear   <= '0;
    end
  end

  p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hwClear));
  p_clr_hwonly_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hwClear & ~HW_CLR_MASK) == '0);
endmodule

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl
  import irqarb_pkg::*;
#(
  parameter int NUM_LVL = LVL_COUNT,
  localparam int LW     = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               globalEn,
  input  logic               sampleStb,
  input  logic               retiPulse,
  input  logic               winValid,
  input  logic [LW-1:0]      winLvl,
  output ctlStb_t            stb,
  output logic               irqReq,
  output logic [NUM_LVL-1:0] inService
);
  logic              topValid;
  logic [LW-1:0]     topLvl;
  logic              accept;
  logic [NUM_LVL-1:0] afterReti;

  always_comb begin
    topLvl = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) topLvl = LW'(l);
  end
  assign topValid  = |inService;
  assign afterReti = inService & ~(NUM_LVL'(1) << topLvl);

  assign accept = sampleStb && globalEn && !retiPulse && winValid &&
                  (!topValid || winLvl > topLvl);
  assign stb.take = accept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      inService <= '0;
    end else begin
      irqReq <= accept;
      if (retiPulse)   inService <= afterReti;
      else if (accept) inService <= inService | (NUM_LVL'(1) << winLvl);
    end
  end

  p_req_on_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $past(sampleStb && globalEn));
  p_preempt_higher_r6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ((inService ^ $past(inService)) > $past(inService)));
  p_accept_sets_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> $countones(inService) == $countones($past(inService)) + 1);
  p_reti_clears_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && topValid) |=>
      $countones(inService) == $countones($past(inService)) - 1);
  p_reti_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    retiPulse |=> !irqReq);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irqarb_pkg::*;
#(
  parameter int NUM_SRC = SRC_COUNT,
  parameter int NUM_LVL = LVL_COUNT,
  localparam int LW     = $clog2(NUM_LVL)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   pendIn,
  input  logic [NUM_SRC-1:0]   srcEn,
  input  logic                 globalEn,
  input  logic [2*NUM_SRC-1:0] srcPrio,
  input  logic                 sampleStb,
  input  logic                 retiPulse,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector,
  output logic [NUM_SRC-1:0]   hwClear,
  output logic [NUM_LVL-1:0]   inService
);
  ctlStb_t       stb;
  logic          winValid;
  logic [LW-1:0] winLvl;

  irqarb_datapath #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_dp (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .srcEn(srcEn),
    .srcPrio(srcPrio), .stb(stb), .winValid(winValid), .winLvl(winLvl),
    .irqVector(irqVector), .hwClear(hwClear)
  );

  irqarb_ctrl #(.NUM_LVL(NUM_LVL)) u_ctl (
    .clk(clk), .rstN(rstN), .globalEn(globalEn), .sampleStb(sampleStb),
    .retiPulse(retiPulse), .winValid(winValid), .winLvl(winLvl),
    .stb(stb), .irqReq(irqReq), .inService(inService)
  );

  p_clr_with_req_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|hwClear) |-> irqReq);
  p_vec_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> irqVector == '0);
  p_vec_form_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqVector[2:0] == 3'b011);
endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] pendIn = '0;
  logic [19:0] srcEn = '0;
  logic        globalEn = 1'b0;
  logic [39:0] srcPrio = '0;
  logic        sampleStb = 1'b0;
  logic        retiPulse = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;
  logic [19:0] hwClear;
  logic [3:0]  inService;

  irq_arbiter u0 (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .srcEn(srcEn),
    .globalEn(globalEn), .srcPrio(srcPrio), .sampleStb(sampleStb),
    .retiPulse(retiPulse), .irqReq(irqReq), .irqVector(irqVector),
    .hwClear(hwClear), .inService(inService)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [3:0] mIsv = '0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    logic        req;
    logic [15:0] vec;
    logic [19:0] clr;
    logic [3:0]  isv;
    string       tag;
  } item_t;
  item_t sbq[$];

  localparam logic [15:0] VTAB [20] = '{
    16'h0003, 16'h000B, 16'h0013, 16'h001B, 16'h0023, 16'h002B, 16'h0033,
    16'h003B, 16'h007B, 16'h0083, 16'h0043, 16'h004B, 16'h0053, 16'h005B,
    16'h0073, 16'h006B, 16'h008B, 16'h0093, 16'h009B, 16'h0063};
  localparam logic [19:0] HWMASK = (20'd1 << 1) | (20'd1 << 3) | (20'd1 << 10) |
                                   (20'd1 << 11) | (20'd1 << 12) | (20'd1 << 13);

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: compare each item on the falling edge of its due cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      item_t it;
      it = sbq.pop_front();
      check(irqReq === it.req, it.tag, "irqReq", 32'(irqReq), 32'(it.req));
      check(irqVector === (it.req ? it.vec : 16'h0), it.tag, "irqVector",
            32'(irqVector), 32'(it.req ? it.vec : 16'h0));
      check(hwClear === it.clr, it.tag, "hwClear", 32'(hwClear), 32'(it.clr));
      check(inService === it.isv, it.tag, "inService", 32'(inService), 32'(it.isv));
    end
  end

  // driver: one cycle of stimulus, pushes its expected result
  task automatic drive(input logic [19:0] p, input logic [19:0] e, input logic ge,
                       input logic [39:0] pr, input logic stb, input logic reti,
                       input string tag);
    item_t it;
    int wl, wi, top;
    @(negedge clk);
    pendIn = p; srcEn = e; globalEn = ge; srcPrio = pr;
    sampleStb = stb; retiPulse = reti;
    it.due = cyc + 1; it.req = 1'b0; it.vec = '0; it.clr = '0; it.tag = tag;
    top = -1;
    for (int l = 0; l < 4; l++) if (mIsv[l]) top = l;
    wl = -1; wi = -1;
    for (int i = 0; i < 20; i++)
      if (p[i] && e[i] && int'(pr[2*i +: 2]) > wl) begin
        wl = int'(pr[2*i +: 2]); wi = i;
      end
    if (reti) begin
      if (top >= 0) mIsv[top] = 1'b0;
    end else if (stb && ge && wi >= 0 && wl > top) begin
      it.req = 1'b1;
      it.vec = VTAB[wi];
      it.clr = HWMASK & (20'd1 << wi);
      mIsv[wl] = 1'b1;
    end
    it.isv = mIsv;
    sbq.push_back(it);
  endtask

  task automatic idle(input string tag);
    drive('0, '0, 1'b1, '0, 1'b0, 1'b0, tag);
  endtask

  function automatic logic [39:0] lv(input int src, input logic [1:0] l,
                                     input logic [39:0] base);
    logic [39:0] r;
    r = base;
    r[2*src +: 2] = l;
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [39:0] pr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(irqReq === 1'b0, "R1", "irqReq", 32'(irqReq), 0);
    check(hwClear === '0, "R1", "hwClear", 32'(hwClear), 0);
    check(inService === '0, "R1", "inService", 32'(inService), 0);
    @(negedge clk); rstN = 1'b1;

    // R2/R5: single source, lowest level
    drive(20'h1, 20'h1, 1, '0, 1, 0, "R2");
    idle("R2");
    drive('0, '0, 1, '0, 0, 1, "R7");
    // pending but no strobe
    drive(20'h1, 20'h1, 1, '0, 0, 0, "R2");
    idle("R2");

    // R8: hardware-cleared timer0
    drive(20'h2, 20'h2, 1, '0, 1, 0, "R8");
    drive('0, '0, 1, '0, 0, 1, "R7");

    // R4: tie at same level, index order beats vector order
    pr = lv(8, 2'd1, lv(10, 2'd1, '0));
    drive((20'd1 << 8) | (20'd1 << 10), '1, 1, pr, 1, 0, "R4");
    drive('0, '0, 1, '0, 0, 1, "R7");
    pr = lv(14, 2'd2, lv(15, 2'd2, '0));
    drive((20'd1 << 14) | (20'd1 << 15), '1, 1, pr, 1, 0, "R4");
    drive('0, '0, 1, '0, 0, 1, "R7");

    // R3: higher level beats lower index
    pr = lv(19, 2'd3, '0);
    drive((20'd1 << 19) | 20'd1, '1, 1, pr, 1, 0, "R3");
    // R6: same level as in service waits
    pr = lv(0, 2'd3, '0);
    drive(20'd1, '1, 1, pr, 1, 0, "R6");
    drive('0, '0, 1, '0, 0, 1, "R7");

    // R6: nesting
    drive(20'd1 << 5, '1, 1, lv(5, 2'd1, '0), 1, 0, "R6");
    drive(20'd1 << 9, '1, 1, lv(9, 2'd1, '0), 1, 0, "R6");
    drive(20'd1 << 9, '1, 1, lv(9, 2'd0, '0), 1, 0, "R6");
    drive(20'd1 << 12, '1, 1, lv(12, 2'd2, '0), 1, 0, "R6");
    drive('0, '0, 1, '0, 0, 1, "R7");
    drive('0, '0, 1, '0, 0, 1, "R7");
    drive('0, '0, 1, '0, 0, 1, "R7");

    // R9: global enable and per-source enable
    drive(20'hFFFFF, '1, 0, '0, 1, 0, "R9");
    drive(20'd1 << 3, ~(20'd1 << 3), 1, '0, 1, 0, "R9");
    idle("R9");

    // R7: return in the same cycle as a strobe
    drive(20'd1, '1, 1, '0, 1, 0, "R7");
    drive(20'd1 << 4, '1, 1, lv(4, 2'd3, '0), 1, 1, "R7");
    idle("R7");

    // R5/R8: every source alone
    for (int s = 0; s < 20; s++) begin
      drive(20'd1 << s, '1, 1, lv(s, 2'd2, '0), 1, 0, "R5");
      drive('0, '0, 1, '0, 0, 1, "R8");
    end

    // R3/R6: random mix
    for (int n = 0; n < 400; n++) begin
      logic [19:0] p;
      p = 20'($urandom) & 20'($urandom) & 20'($urandom);
      drive(p, 20'($urandom) | 20'($urandom), ($urandom % 8) != 0,
            {8'($urandom), 32'($urandom)}, ($urandom % 2) == 0,
            ($urandom % 4) == 0, "R6");
    end
    idle("R6");
    idle("R6");
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule